// File: doc/BRIEF.md
# JTAG Debug Port Scan Master

This block drives a JTAG test access port to carry out register transactions on a debug port. The requester gives a request with a target selector (debug-port register or access-port register), a two-bit register address, a read/write flag and a 32-bit write word. The master loads the matching instruction into the TAP's instruction register and performs one 35-bit data register scan. It then returns the 3-bit acknowledge and the 32-bit word captured on that scan, together with a one-cycle completion pulse.

Reads on this port are posted. The word captured during a read scan is the result of the operation before it, and the current result is only collected by a later read of the port's read-buffer register. The master does not hide this: it returns exactly what the scan captured. An instruction that is already loaded is not scanned again. A separate request kind issues the abort write. Accesses that start a memory-bus transfer can be followed by a programmable number of TCK cycles spent in Run-Test/Idle, which gives the target time to finish the transfer.

TCK is derived from the system clock. TMS and TDI change only on falling TCK edges, and TDO is sampled on rising edges.

Top module: `jscan_master`

## Requirements
- R1: After reset, TCK is low, TMS is high, req_ready and done are low, and TMS stays high for five rising TCK edges and is then low for one, leaving the TAP in Run-Test/Idle with its reset instruction (IDCODE, 4'hE). req_ready then rises.
- R2: TCK is high for TCK_HALF system clocks and low for TCK_HALF system clocks. TMS changes only in the cycle in which TCK falls.
- R3: A debug-port request loads instruction 4'hA and an access-port request loads 4'hB, shifted least significant bit first.
- R4: Each request performs exactly one 35-bit data scan, shifted LSB first, with bit 0 = read flag (1 = read), bits [2:1] = register address and bits [34:3] = write word. TDI changes only as TCK falls.
- R5: done is a one-cycle pulse. With it, rsp_ack holds the first 3 bits captured from TDO (bit 0 first) and rsp_data holds the following 32 bits.
- R6: The instruction scan is skipped when the requested instruction equals the one last loaded. After reset the loaded instruction is taken to be 4'hE.
- R7: Every scan ends in Run-Test/Idle. TMS is low whenever req_ready is high and in the cycle done is high.
- R8: An access-port request with req_memdata high and a nonzero pause_tck spends exactly pause_tck extra rising TCK edges in Run-Test/Idle after Update-DR and before done. Debug-port requests, req_memdata low or pause_tck = 0 add none.
- R9: With req_abort high the master loads instruction 4'h8 and scans register address 0, write flag (bit 0 = 0) and data value 1, whatever the other request fields hold, and adds no pause.
- R10: A request is taken only while req_ready is high. req_ready stays low from the cycle after acceptance until done. Request inputs that change after acceptance do not alter the scan in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle in Run-Test/Idle and able to take a request |
| req_abort | input | 1 | Issue the abort write instead of a register access |
| req_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| req_addr | input | 2 | Register address bits A[3:2] |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_wdata | input | DATA_W | Write word |
| req_memdata | input | 1 | Access targets a memory data register; allows the idle pause |
| pause_tck | input | PAUSE_W | Extra Run-Test/Idle TCK cycles after a memory data access |
| done | output | 1 | One-cycle completion pulse |
| rsp_ack | output | 3 | Acknowledge captured on the scan (3'b010 OK/FAULT, 3'b001 WAIT) |
| rsp_data | output | DATA_W | Word captured on the scan (posted result of the prior operation) |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the TAP |
| tdo | input | 1 | Test data from the TAP |

## Verification
Two situations are hard to reach from the ports. The first is a reset that lands in the middle of a data scan. The master must then return the TAP to Test-Logic-Reset from an arbitrary state and forget which instruction it had cached. The bench starts its TAP model in Shift-DR, and later drops reset sixty cycles into a scan. In both cases it checks that the model ends in Run-Test/Idle holding the reset instruction. The second is the exact pause length. The bench model counts rising TCK edges taken in Run-Test/Idle after Update-DR, and the stimulus covers zero, one, five and 255 extra edges, plus cases where the memory flag is missing or the target is the debug port.

// File: rtl/jscan_pkg.sv
package jscan_pkg;

    // Instruction register codes (low four bits; zero-extended to IR_LEN).
    localparam logic [3:0] INSN_ABORT_C = 4'h8;
    localparam logic [3:0] INSN_DP_C    = 4'hA;
    localparam logic [3:0] INSN_AP_C    = 4'hB;
    localparam logic [3:0] INSN_ID_C    = 4'hE;

    // Acknowledge codes returned in the first three captured bits.
    localparam logic [2:0] ACK_OKFAULT_C = 3'b010;
    localparam logic [2:0] ACK_WAIT_C    = 3'b001;

    // Width of the header field ahead of the data word (address + read flag).
    localparam int HDR_W = 3;

    // Number of TMS-high edges used to force Test-Logic-Reset.
    localparam int TLR_ONES = 5;

    typedef enum logic [3:0] {
        PH_RESET,
        PH_IDLE,
        PH_IR_HEAD,
        PH_IR_SHIFT,
        PH_IR_TAIL,
        PH_DR_HEAD,
        PH_DR_SHIFT,
        PH_DR_TAIL,
        PH_PAUSE
    } phase_e;

endpackage

// File: rtl/jscan_tck_gen.sv
module jscan_tck_gen #(
    parameter int TCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tck,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (TCK_HALF > 1) ? $clog2(TCK_HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tck;
    } tg_t;

    tg_t  s_d, s_q;
    logic wrap;

    always_comb begin
        s_d  = s_q;
        wrap = (s_q.cnt == CW'(TCK_HALF - 1));
        if (wrap) begin
            s_d.cnt = '0;
            s_d.tck = ~s_q.tck;
        end else begin
            s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tck      = s_q.tck;
    assign rise_stb = wrap && !s_q.tck;
    assign fall_stb = wrap &&  s_q.tck;

endmodule

// File: rtl/jscan_shreg.sv
module jscan_shreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         sin,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;
    logic [W-1:0] shifted;

    generate
        if (W == 1) begin : g_single
            assign shifted = sin;
        end else begin : g_multi
            assign shifted = {sin, q_q[W-1:1]};
        end
    endgenerate

    always_comb begin
        q_d = q_q;
        if (load)       q_d = load_val;
        else if (shift) q_d = shifted;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign q = q_q;

endmodule

// File: rtl/jscan_seq.sv
module jscan_seq
    import jscan_pkg::*;
#(
    parameter int IR_LEN  = 4,
    parameter int DATA_W  = 32,
    parameter int PAUSE_W = 8,
    parameter int DR_LEN  = DATA_W + HDR_W,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise_stb,
    input  logic               fall_stb,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_abort,
    input  logic               req_ap,
    input  logic [1:0]         req_addr,
    input  logic               req_rnw,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               req_memdata,
    input  logic [PAUSE_W-1:0] pause_tck,
    input  logic [IR_LEN-1:0]  ir_word,
    input  logic [DR_LEN-1:0]  dr_word,
    output logic               ir_load,
    output logic [IR_LEN-1:0]  ir_load_val,
    output logic               ir_shift,
    output logic               dr_load,
    output logic [DR_LEN-1:0]  dr_load_val,
    output logic               dr_shift,
    output logic               tms,
    output logic               tdi,
    output logic               done,
    output logic [HDR_W-1:0]   rsp_ack,
    output logic [DATA_W-1:0]  rsp_data
);
    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [PAUSE_W-1:0] pause;
        logic [IR_LEN-1:0]  cur_ir;
        logic               tms;
        logic               tdi;
        logic               done;
        logic [HDR_W-1:0]   ack;
        logic [DATA_W-1:0]  data;
    } sq_t;

    sq_t  s_d, s_q;
    logic finish;
    logic use_pause;

    // TMS value to present for a given step of a given phase.
    function automatic logic tms_of(input phase_e ph, input logic [CNT_W-1:0] c);
        case (ph)
            PH_RESET:    return c < CNT_W'(TLR_ONES);
            PH_IR_HEAD:  return c < CNT_W'(2);
            PH_IR_SHIFT: return c == CNT_W'(IR_LEN - 1);
            PH_IR_TAIL:  return c == '0;
            PH_DR_HEAD:  return c == '0;
            PH_DR_SHIFT: return c == CNT_W'(DR_LEN - 1);
            PH_DR_TAIL:  return c == '0;
            default:     return 1'b0;
        endcase
    endfunction

    always_comb begin
        ir_load_val = req_abort ? IR_LEN'(INSN_ABORT_C)
                    : (req_ap   ? IR_LEN'(INSN_AP_C) : IR_LEN'(INSN_DP_C));
        dr_load_val = req_abort ? {DATA_W'(1), HDR_W'(0)}
                    : {req_wdata, req_addr, req_rnw};
        use_pause   = req_ap && !req_abort && req_memdata;
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        finish   = 1'b0;
        ir_load  = 1'b0;
        dr_load  = 1'b0;
        ir_shift = 1'b0;
        dr_shift = 1'b0;

        // Rising TCK: the TAP takes the presented step; advance the walk.
        if (rise_stb) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
            case (s_q.phase)
                PH_RESET: if (s_q.cnt == CNT_W'(TLR_ONES)) begin
                    s_d.phase  = PH_IDLE;
                    s_d.cnt    = '0;
                    s_d.cur_ir = IR_LEN'(INSN_ID_C);
                end
                PH_IDLE: s_d.cnt = '0;
                PH_IR_HEAD: if (s_q.cnt == CNT_W'(3)) begin
                    s_d.phase = PH_IR_SHIFT;
                    s_d.cnt   = '0;
                end
                PH_IR_SHIFT: begin
                    ir_shift = 1'b1;
                    if (s_q.cnt == CNT_W'(IR_LEN - 1)) begin
                        s_d.phase = PH_IR_TAIL;
                        s_d.cnt   = '0;
                    end
                end
                PH_IR_TAIL: if (s_q.cnt == CNT_W'(1)) begin
                    s_d.phase = PH_DR_HEAD;
                    s_d.cnt   = '0;
                end
                PH_DR_HEAD: if (s_q.cnt == CNT_W'(2)) begin
                    s_d.phase = PH_DR_SHIFT;
                    s_d.cnt   = '0;
                end
                PH_DR_SHIFT: begin
                    dr_shift = 1'b1;
                    if (s_q.cnt == CNT_W'(DR_LEN - 1)) begin
                        s_d.phase = PH_DR_TAIL;
                        s_d.cnt   = '0;
                    end
                end
                PH_DR_TAIL: if (s_q.cnt == CNT_W'(1)) begin
                    if (s_q.pause != '0) begin
                        s_d.phase = PH_PAUSE;
                        s_d.cnt   = '0;
                    end else begin
                        finish = 1'b1;
                    end
                end
                PH_PAUSE: if (s_q.cnt + CNT_W'(1) == CNT_W'(s_q.pause)) begin
                    finish = 1'b1;
                end
                default: s_d.phase = PH_RESET;
            endcase
            if (finish) begin
                s_d.phase = PH_IDLE;
                s_d.cnt   = '0;
                s_d.done  = 1'b1;
                s_d.ack   = dr_word[HDR_W-1:0];
                s_d.data  = dr_word[DR_LEN-1:HDR_W];
            end
        end

        // Falling TCK: accept a request if idle, then present the next step.
        if (fall_stb) begin
            if (s_q.phase == PH_IDLE && req_valid) begin
                ir_load    = 1'b1;
                dr_load    = 1'b1;
                s_d.cnt    = '0;
                s_d.pause  = use_pause ? pause_tck : '0;
                s_d.cur_ir = ir_load_val;
                s_d.phase  = (ir_load_val == s_q.cur_ir) ? PH_DR_HEAD : PH_IR_HEAD;
            end
            s_d.tms = tms_of(s_d.phase, s_d.cnt);
            s_d.tdi = (s_d.phase == PH_IR_SHIFT) ? ir_word[0]
                    : (s_d.phase == PH_DR_SHIFT) ? dr_word[0] : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.phase  <= PH_RESET;
            s_q.tms    <= 1'b1;
            s_q.cur_ir <= IR_LEN'(INSN_ID_C);
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready = (s_q.phase == PH_IDLE);
    assign tms       = s_q.tms;
    assign tdi       = s_q.tdi;
    assign done      = s_q.done;
    assign rsp_ack   = s_q.ack;
    assign rsp_data  = s_q.data;

    // R5: completion is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: idle is left only when a request was presented
    assert_ready_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> $past(req_valid));

    // R7: while waiting for work the TAP is parked with TMS low
    assert_ready_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !tms);

endmodule

// File: rtl/jscan_master.sv
module jscan_master
    import jscan_pkg::*;
#(
    parameter int IR_LEN   = 4,
    parameter int DATA_W   = 32,
    parameter int PAUSE_W  = 8,
    parameter int TCK_HALF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_abort,
    input  logic               req_ap,
    input  logic [1:0]         req_addr,
    input  logic               req_rnw,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               req_memdata,
    input  logic [PAUSE_W-1:0] pause_tck,
    output logic               done,
    output logic [2:0]         rsp_ack,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               tck,
    output logic               tms,
    output logic               tdi,
    input  logic               tdo
);
    localparam int DR_LEN = DATA_W + HDR_W;
    localparam int DR_CW  = $clog2(DR_LEN + 1);
    localparam int CNT_W  = (DR_CW > PAUSE_W) ? DR_CW : PAUSE_W;

    logic              rise_stb, fall_stb;
    logic              ir_load, ir_shift, dr_load, dr_shift;
    logic [IR_LEN-1:0] ir_word, ir_load_val;
    logic [DR_LEN-1:0] dr_word, dr_load_val;

    jscan_tck_gen #(.TCK_HALF(TCK_HALF)) u_tck (
        .clk      (clk),
        .rst_n    (rst_n),
        .tck      (tck),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    jscan_shreg #(.W(IR_LEN)) u_ir (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ir_load),
        .load_val (ir_load_val),
        .shift    (ir_shift),
        .sin      (1'b0),
        .q        (ir_word)
    );

    jscan_shreg #(.W(DR_LEN)) u_dr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (dr_load),
        .load_val (dr_load_val),
        .shift    (dr_shift),
        .sin      (tdo),
        .q        (dr_word)
    );

    jscan_seq #(
        .IR_LEN  (IR_LEN),
        .DATA_W  (DATA_W),
        .PAUSE_W (PAUSE_W),
        .DR_LEN  (DR_LEN),
        .CNT_W   (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_stb    (rise_stb),
        .fall_stb    (fall_stb),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_abort   (req_abort),
        .req_ap      (req_ap),
        .req_addr    (req_addr),
        .req_rnw     (req_rnw),
        .req_wdata   (req_wdata),
        .req_memdata (req_memdata),
        .pause_tck   (pause_tck),
        .ir_word     (ir_word),
        .dr_word     (dr_word),
        .ir_load     (ir_load),
        .ir_load_val (ir_load_val),
        .ir_shift    (ir_shift),
        .dr_load     (dr_load),
        .dr_load_val (dr_load_val),
        .dr_shift    (dr_shift),
        .tms         (tms),
        .tdi         (tdi),
        .done        (done),
        .rsp_ack     (rsp_ack),
        .rsp_data    (rsp_data)
    );

    // R2: TMS moves only together with a falling TCK
    assert_tms_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tms) |-> $fell(tck));

    // R4: TDI moves only together with a falling TCK
    assert_tdi_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tdi) |-> $fell(tck));

    // R7: a finished transaction leaves TMS low (TAP in Run-Test/Idle)
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !tms);

endmodule

// File: tb/jscan_master_tb_top.sv
`timescale 1ns/1ps
module jscan_master_tb_top;

    localparam int TCK_HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_abort = 1'b0;
    logic        req_ap = 1'b0;
    logic [1:0]  req_addr = '0;
    logic        req_rnw = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_memdata = 1'b0;
    logic [7:0]  pause_tck = '0;
    logic        req_ready, done, tck, tms, tdi;
    logic [2:0]  rsp_ack;
    logic [31:0] rsp_data;
    logic        tdo = 1'b0;

    always #2 clk = ~clk;

    jscan_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_abort(req_abort), .req_ap(req_ap), .req_addr(req_addr),
        .req_rnw(req_rnw), .req_wdata(req_wdata), .req_memdata(req_memdata),
        .pause_tck(pause_tck), .done(done), .rsp_ack(rsp_ack),
        .rsp_data(rsp_data), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    // ---------------- TAP target model ----------------
    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SDR, T_CDR, T_SHD, T_E1D, T_PDR, T_E2D, T_UDR,
        T_SIR, T_CIR, T_SHI, T_E1I, T_PIR, T_E2I, T_UIR
    } tap_e;

    tap_e        st = T_SHD;
    logic [34:0] cap_val = '0;
    logic [34:0] dr_sr = '0;
    logic [34:0] last_dr = '0;
    logic [3:0]  ir_sr = '0;
    logic [3:0]  ir_reg = 4'h0;
    int          dr_n = 0, last_dr_n = 0, ir_upd = 0, idle_rises = 0;

    always @(posedge tck) begin
        case (st)
            T_TLR: begin ir_reg <= 4'hE; st <= tms ? T_TLR : T_RTI; end
            T_RTI: begin idle_rises <= idle_rises + 1; st <= tms ? T_SDR : T_RTI; end
            T_SDR: st <= tms ? T_SIR : T_CDR;
            T_CDR: begin dr_sr <= cap_val; dr_n <= 0; st <= tms ? T_E1D : T_SHD; end
            T_SHD: begin dr_sr <= {tdi, dr_sr[34:1]}; dr_n <= dr_n + 1; st <= tms ? T_E1D : T_SHD; end
            T_E1D: st <= tms ? T_UDR : T_PDR;
            T_PDR: st <= tms ? T_E2D : T_PDR;
            T_E2D: st <= tms ? T_UDR : T_SHD;
            T_UDR: begin last_dr <= dr_sr; last_dr_n <= dr_n; idle_rises <= 0; st <= tms ? T_SDR : T_RTI; end
            T_SIR: st <= tms ? T_TLR : T_CIR;
            T_CIR: begin ir_sr <= 4'b0001; st <= tms ? T_E1I : T_SHI; end
            T_SHI: begin ir_sr <= {tdi, ir_sr[3:1]}; st <= tms ? T_E1I : T_SHI; end
            T_E1I: st <= tms ? T_UIR : T_PIR;
            T_PIR: st <= tms ? T_E2I : T_PIR;
            T_E2I: st <= tms ? T_UIR : T_SHI;
            T_UIR: begin ir_reg <= ir_sr; ir_upd <= ir_upd + 1; st <= tms ? T_SDR : T_RTI; end
            default: st <= T_TLR;
        endcase
    end

    always @(negedge tck)
        tdo <= (st == T_SHD) ? dr_sr[0] : ((st == T_SHI) ? ir_sr[0] : 1'b0);

    // ---------------- bookkeeping ----------------
    int checks = 0, bad = 0, glitches = 0;
    logic tms_prev = 1'b1, tck_prev = 1'b0;
    bit   finished = 1'b0;

    always @(negedge clk) begin
        if (rst_n && (tms !== tms_prev) && !(tck_prev && !tck)) glitches++;
        tms_prev <= tms;
        tck_prev <= tck;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- stimulus vectors ----------------
    typedef struct packed {
        logic        abrt;
        logic        ap;
        logic [1:0]  addr;
        logic        rnw;
        logic        mem;
        logic [7:0]  pause;
        logic [31:0] wdata;
        logic [2:0]  ack;
        logic [31:0] cap;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'd1, 1'b1, 1'b0, 8'd0,   32'h0000_0000, 3'b010, 32'h1234_5678},
        '{1'b0, 1'b0, 2'd3, 1'b1, 1'b0, 8'd0,   32'h0000_0000, 3'b010, 32'hCAFE_F00D},
        '{1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 8'd5,   32'hA5A5_0F0F, 3'b001, 32'h0000_0000},
        '{1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 8'd0,   32'h0000_0000, 3'b010, 32'hDEAD_BEEF},
        '{1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 8'd7,   32'h0000_FFFF, 3'b010, 32'h8000_0001},
        '{1'b0, 1'b0, 2'd2, 1'b0, 1'b1, 8'd3,   32'h5A5A_5A5A, 3'b100, 32'h7FFF_FFFE},
        '{1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 8'd9,   32'hFFFF_FFFF, 3'b010, 32'h0000_0001},
        '{1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 8'd1,   32'h1111_2222, 3'b010, 32'h3333_4444},
        '{1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 8'd255, 32'h0000_0000, 3'b001, 32'hFFFF_FFFF}
    };

    task automatic issue(input vec_t v, input bit scramble);
        cap_val = {v.cap, v.ack};
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid   = 1'b1;
        req_abort   = v.abrt;
        req_ap      = v.ap;
        req_addr    = v.addr;
        req_rnw     = v.rnw;
        req_wdata   = v.wdata;
        req_memdata = v.mem;
        pause_tck   = v.pause;
        @(negedge clk);
        while (req_ready) @(negedge clk);
        req_valid = 1'b0;
        if (scramble) begin
            req_abort = ~v.abrt; req_ap = ~v.ap; req_addr = ~v.addr;
            req_rnw = ~v.rnw; req_wdata = ~v.wdata; req_memdata = ~v.mem;
            pause_tck = ~v.pause;
        end
        chk("R10 ready low while busy", {63'd0, req_ready}, 64'd0);
        while (!done) @(negedge clk);
    endtask

    logic [3:0] exp_ir;

    initial begin
        // ---------- reset state ----------
        repeat (3) @(negedge clk);
        chk("R1 reset req_ready", {63'd0, req_ready}, 64'd0);
        chk("R1 reset done", {63'd0, done}, 64'd0);
        chk("R1 reset tck", {63'd0, tck}, 64'd0);
        chk("R1 reset tms", {63'd0, tms}, 64'd1);
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        chk("R1 TAP idle after walk", {60'd0, st}, {60'd0, T_RTI});
        chk("R1 IDCODE loaded after walk", {60'd0, ir_reg}, 64'hE);
        chk("R7 tms low when ready", {63'd0, tms}, 64'd0);

        // ---------- TCK half period ----------
        begin
            time t0;
            @(posedge tck); t0 = $time;
            @(negedge tck);
            chk("R2 tck high time", 64'(($time - t0) / 4), 64'(TCK_HALF));
            t0 = $time;
            @(posedge tck);
            chk("R2 tck low time", 64'(($time - t0) / 4), 64'(TCK_HALF));
        end

        // ---------- vector table ----------
        exp_ir = 4'hE;
        for (int i = 0; i < NV; i++) begin
            vec_t        v;
            logic [3:0]  ins;
            logic [34:0] edr;
            int          upd0, epause;
            v      = VECS[i];
            ins    = v.abrt ? 4'h8 : (v.ap ? 4'hB : 4'hA);
            edr    = v.abrt ? {32'd1, 2'b00, 1'b0} : {v.wdata, v.addr, v.rnw};
            epause = (!v.abrt && v.ap && v.mem) ? int'(v.pause) : 0;
            upd0   = ir_upd;
            issue(v, 1'b0);
            chk($sformatf("R5 ack vec%0d", i), {61'd0, rsp_ack}, {61'd0, v.ack});
            chk($sformatf("R5 data vec%0d", i), {32'd0, rsp_data}, {32'd0, v.cap});
            chk($sformatf("R4 R9 dr bits vec%0d", i), {29'd0, last_dr}, {29'd0, edr});
            chk($sformatf("R4 dr length vec%0d", i), 64'(last_dr_n), 64'd35);
            chk($sformatf("R3 R9 instruction vec%0d", i), {60'd0, ir_reg}, {60'd0, ins});
            chk($sformatf("R6 ir scans vec%0d", i), 64'(ir_upd - upd0), (ins == exp_ir) ? 64'd0 : 64'd1);
            chk($sformatf("R8 pause vec%0d", i), 64'(idle_rises), 64'(epause));
            chk($sformatf("R7 idle at done vec%0d", i), {60'd0, st}, {60'd0, T_RTI});
            @(negedge clk);
            chk($sformatf("R5 done pulse vec%0d", i), {63'd0, done}, 64'd0);
            exp_ir = ins;
        end

        // ---------- inputs changed after acceptance ----------
        begin
            vec_t v;
            v = '{1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 8'd0, 32'h0F0F_0F0F, 3'b010, 32'h2468_ACE0};
            issue(v, 1'b1);
            chk("R10 scan unaffected by later inputs", {29'd0, last_dr}, {29'd0, 32'h0F0F_0F0F, 2'd1, 1'b0});
            chk("R10 no pause from later inputs", 64'(idle_rises), 64'd0);
            chk("R3 debug port instruction", {60'd0, ir_reg}, 64'hA);
        end

        // ---------- reset in the middle of a scan ----------
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_abort = 1'b0; req_ap = 1'b1; req_addr = 2'd3;
        req_rnw = 1'b0; req_wdata = 32'h7777_7777; req_memdata = 1'b0;
        @(negedge clk);
        while (req_ready) @(negedge clk);
        req_valid = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 mid-scan reset ready low", {63'd0, req_ready}, 64'd0);
        rst_n = 1'b1;
        while (!req_ready) @(negedge clk);
        chk("R1 TAP idle after mid-scan reset", {60'd0, st}, {60'd0, T_RTI});
        chk("R1 IDCODE after mid-scan reset", {60'd0, ir_reg}, 64'hE);
        begin
            vec_t v;
            int   upd0;
            v    = '{1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 8'd0, 32'h0, 3'b010, 32'h0BAD_F00D};
            upd0 = ir_upd;
            issue(v, 1'b0);
            chk("R6 cache cleared by reset", 64'(ir_upd - upd0), 64'd1);
            chk("R5 data after reset", {32'd0, rsp_data}, 64'h0BAD_F00D);
        end

        chk("R2 tms changes only at tck fall", 64'(glitches), 64'd0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        #600000;
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule